// File: doc/BRIEF.md
# Command packet framer

The framer takes a stream of 32-bit command words on a valid/ready input and cuts it into whole command packets. The top byte of the first word of a packet is its opcode. A length decoder turns the opcode into the number of words that follow it. The framer holds the words of a packet in a small buffer until the packet is complete. It then replays the packet on a renderer-side stream, marking the first word and the last word. The input is stalled while that replay runs.

While it frames packets, the block snoops certain commands. The 0xE0 to 0xE7 settings commands are copied into eight shadow registers. Textured polygon commands patch the texture-page field of shadow register 1, and a 13-bit status word is refreshed from the shadows. A sticky dirty flag records that a drawing or memory command was seen.

The image-transfer opcodes are not forwarded. Instead they produce a start pulse for a transfer engine, carrying the position word and the size word. A write transfer then turns the input into a plain data pipe to the engine until the engine reports that it is done.

Top module: `cmd_framer`

## Requirements
- R1: After reset, in_ready_o is 1, and pkt_valid_o, xfer_start_o and dirty_o are 0. status_o is 0 and every shadow register is 0.
- R2: Packet length is 1 plus a per-opcode count: 0x20-0x23 give 4 words, 0x3C-0x3F give 12, 0x60-0x63 give 3, 0x68-0x6B give 2, 0x80 gives 4 and 0x02 gives 3. The words leave on pkt_data_o in arrival order, with pkt_sop_o on the first word only and pkt_eop_o on the last word only.
- R3: An opcode whose count is zero is forwarded as a one-word packet with pkt_sop_o and pkt_eop_o both set. This covers 0x00, 0x1F, 0x6C-0x6F and 0xE0-0xE7.
- R4: While pkt_valid_o is 1 and pkt_ready_i is 0, pkt_data_o, pkt_sop_o and pkt_eop_o hold their values into the next cycle.
- R5: A packet with opcode 0xE0+n (n = 0..7) stores its whole word in shadow register n. Shadow n is the slice shadow_o[32n+31:32n] and is visible from the cycle after the word is accepted.
- R6: When (opcode & 0xF4) == 0x24, bits 8:0 of shadow register 1 take bits 8:0 of packet word index 4 (the fifth word). When (opcode & 0xF4) == 0x34, they take word index 5 instead. The other bits of shadow 1 are unchanged.
- R7: dirty_o becomes 1 when a packet with an opcode in the range 0x02 to 0xBF completes. It stays 0 for opcodes 0x00, 0x01 and 0xC0 and above. dirty_clr_i clears it, but a setting packet completing in the same cycle wins.
- R8: A packet with opcode 0xA0 (write) or 0xC0 (read) is 3 words long and is not forwarded. For one cycle it raises xfer_start_o, with xfer_read_o set to 1 only for 0xC0. xfer_pos_o carries word index 1 and xfer_size_o carries word index 2.
- R9: After a write start, every input word is accepted and passed on xfer_wvalid_o/xfer_wdata_o without being parsed, until an xfer_done_i pulse. Such words do not reach the packet port or the shadows.
- R10: One cycle after a packet completes, status_o[10:0] is loaded from shadow 1 bits 10:0 and status_o[12:11] from shadow 6 bits 1:0.
- R11: While a packet is being forwarded, in_ready_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input word valid |
| in_data_i | input | 32 | Input command word |
| in_ready_o | output | 1 | Input word accepted |
| pkt_valid_o | output | 1 | Forwarded word valid |
| pkt_data_o | output | 32 | Forwarded word |
| pkt_sop_o | output | 1 | First word of packet |
| pkt_eop_o | output | 1 | Last word of packet |
| pkt_ready_i | input | 1 | Renderer accepts word |
| xfer_start_o | output | 1 | Transfer start pulse |
| xfer_read_o | output | 1 | Transfer is a read |
| xfer_pos_o | output | 32 | Transfer position word |
| xfer_size_o | output | 32 | Transfer size word |
| xfer_wvalid_o | output | 1 | Write-transfer data valid |
| xfer_wdata_o | output | 32 | Write-transfer data word |
| xfer_done_i | input | 1 | Write transfer finished |
| shadow_o | output | 256 | Eight shadow registers, register n at bits 32n+31:32n |
| status_o | output | 13 | Status bits from shadows 1 and 6 |
| dirty_o | output | 1 | Sticky drawing activity flag |
| dirty_clr_i | input | 1 | Clear dirty flag |

## Verification
The hardest state to reach is a pending write transfer. In that state a word that looks like a settings command must pass through untouched. The stimulus first completes a 0xA0 packet. It then sends a 0xE3-headed word as transfer data and confirms that shadow 3 is unchanged and no packet appears. After an xfer_done_i pulse it sends the same opcode as a real command and sees it take effect. Backpressure is covered by a renderer-ready pattern that both toggles and holds low in the middle of 4-word and 12-word packets.

// File: rtl/cmd_framer_pkg.sv
`timescale 1ns/1ps
package cmd_framer_pkg;
  typedef enum logic {ST_COLLECT = 1'b0, ST_SEND = 1'b1} frm_state_e;

  localparam logic [7:0] OP_XFER_WR = 8'hA0;
  localparam logic [7:0] OP_XFER_RD = 8'hC0;
  localparam int         TEX_SH     = 1;
  localparam int         MASK_SH    = 6;
  localparam int         STAT_W     = 13;
endpackage

// File: rtl/cmd_len_dec.sv
`timescale 1ns/1ps
module cmd_len_dec #(
  parameter int CNT_W = 4
) (
  input  logic [7:0]       op_i,
  output logic [CNT_W-1:0] extra_o
);
  logic [3:0] nv;
  logic [3:0] ex;

  always_comb begin
    nv = op_i[3] ? 4'd4 : 4'd3;
    ex = 4'd0;
    case (op_i[7:5])
      3'd0: ex = (op_i == 8'h02) ? 4'd2 : 4'd0;
      // polygons: vertices x (1 + uv) plus colours after the first
      3'd1: ex = (op_i[2] ? (nv << 1) : nv) + (op_i[4] ? nv - 4'd1 : 4'd0);
      3'd2: ex = 4'd2 + {3'd0, op_i[3]} + {3'd0, op_i[4]};
      3'd3: ex = (op_i[4:2] == 3'b011) ? 4'd0
               : 4'd1 + {3'd0, (op_i[4:3] == 2'b00)} + {3'd0, op_i[2]};
      3'd4: ex = (op_i == 8'h80) ? 4'd3 : 4'd0;
      3'd5: ex = (op_i == 8'hA0) ? 4'd2 : 4'd0;
      3'd6: ex = (op_i == 8'hC0) ? 4'd2 : 4'd0;
      default: ex = 4'd0;
    endcase
    extra_o = CNT_W'(ex);
  end
endmodule

// File: rtl/cmd_shadow.sv
`timescale 1ns/1ps
module cmd_shadow
  import cmd_framer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_SH = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     done_i,
  input  logic [7:0]               op_i,
  input  logic [DATA_W-1:0]        w0_i,
  input  logic [DATA_W-1:0]        tex_w_i,
  input  logic                     dirty_clr_i,
  output logic [NUM_SH*DATA_W-1:0] shadow_o,
  output logic [STAT_W-1:0]        status_o,
  output logic                     dirty_o
);
  localparam int SEL_W = $clog2(NUM_SH);

  logic [DATA_W-1:0] sh_q [NUM_SH];
  logic              is_set, tex_hit, upd_q, dirty_q;
  logic [STAT_W-1:0] status_q;

  assign is_set  = (op_i[7:3] == 5'h1C);
  assign tex_hit = ((op_i & 8'hF4) == 8'h24) || ((op_i & 8'hF4) == 8'h34);

  for (genvar g = 0; g < NUM_SH; g++) begin : g_sh
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sh_q[g] <= '0;
      end else if (done_i) begin
        if (is_set && op_i[SEL_W-1:0] == SEL_W'(g)) sh_q[g] <= w0_i;
        else if (g == TEX_SH && tex_hit)           sh_q[g][8:0] <= tex_w_i[8:0];
      end
    end
    assign shadow_o[g*DATA_W +: DATA_W] = sh_q[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upd_q    <= 1'b0;
      status_q <= '0;
      dirty_q  <= 1'b0;
    end else begin
      upd_q <= done_i;
      if (upd_q) status_q <= {sh_q[MASK_SH][1:0], sh_q[TEX_SH][10:0]};
      if (done_i && op_i >= 8'h02 && op_i < 8'hC0) dirty_q <= 1'b1;
      else if (dirty_clr_i)                        dirty_q <= 1'b0;
    end
  end

  assign status_o = status_q;
  assign dirty_o  = dirty_q;

  // R7
  dirty_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dirty_o && !done_i) |=> !dirty_o);
  // R10
  status_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o != $past(status_o)) |-> $past(done_i, 2));
endmodule

// File: rtl/cmd_framer.sv
`timescale 1ns/1ps
module cmd_framer
  import cmd_framer_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int BUF_DEPTH = 12,
  parameter int NUM_SH    = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     in_valid_i,
  input  logic [DATA_W-1:0]        in_data_i,
  output logic                     in_ready_o,
  output logic                     pkt_valid_o,
  output logic [DATA_W-1:0]        pkt_data_o,
  output logic                     pkt_sop_o,
  output logic                     pkt_eop_o,
  input  logic                     pkt_ready_i,
  output logic                     xfer_start_o,
  output logic                     xfer_read_o,
  output logic [DATA_W-1:0]        xfer_pos_o,
  output logic [DATA_W-1:0]        xfer_size_o,
  output logic                     xfer_wvalid_o,
  output logic [DATA_W-1:0]        xfer_wdata_o,
  input  logic                     xfer_done_i,
  output logic [NUM_SH*DATA_W-1:0] shadow_o,
  output logic [STAT_W-1:0]        status_o,
  output logic                     dirty_o,
  input  logic                     dirty_clr_i
);
  localparam int CNT_W = $clog2(BUF_DEPTH + 1);

  frm_state_e        state_q;
  logic [DATA_W-1:0] buf_q [BUF_DEPTH];
  logic [CNT_W-1:0]  cnt_q, need_q, rd_q, extra, need_now;
  logic [7:0]        op_q, cur_op;
  logic              wr_pend_q, xs_q, xr_q;
  logic [DATA_W-1:0] xpos_q, xsize_q, w0, tex_w;
  logic              acc, done, is_xfer;

  cmd_len_dec #(.CNT_W(CNT_W)) u_len (
    .op_i    (in_data_i[DATA_W-1 -: 8]),
    .extra_o (extra)
  );

  assign in_ready_o = (state_q == ST_COLLECT);
  assign acc        = in_valid_i && in_ready_o && !wr_pend_q;
  assign cur_op     = (cnt_q == '0) ? in_data_i[DATA_W-1 -: 8] : op_q;
  assign need_now   = (cnt_q == '0) ? extra + CNT_W'(1) : need_q;
  assign done       = acc && (cnt_q + CNT_W'(1) == need_now);
  assign is_xfer    = (cur_op == OP_XFER_WR) || (cur_op == OP_XFER_RD);
  assign w0         = (cnt_q == '0) ? in_data_i : buf_q[0];
  // texture word always precedes the last word, so it is already buffered
  assign tex_w      = cur_op[4] ? buf_q[5] : buf_q[4];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_COLLECT;
      cnt_q     <= '0;
      need_q    <= '0;
      rd_q      <= '0;
      op_q      <= '0;
      wr_pend_q <= 1'b0;
      xs_q      <= 1'b0;
      xr_q      <= 1'b0;
      xpos_q    <= '0;
      xsize_q   <= '0;
      for (int i = 0; i < BUF_DEPTH; i++) buf_q[i] <= '0;
    end else begin
      xs_q <= 1'b0;
      case (state_q)
        ST_COLLECT: begin
          if (wr_pend_q) begin
            if (xfer_done_i) wr_pend_q <= 1'b0;
          end else if (acc) begin
            buf_q[cnt_q] <= in_data_i;
            if (cnt_q == '0) begin
              op_q   <= in_data_i[DATA_W-1 -: 8];
              need_q <= need_now;
            end
            if (done) begin
              cnt_q <= '0;
              if (is_xfer) begin
                xs_q      <= 1'b1;
                xr_q      <= (cur_op == OP_XFER_RD);
                xpos_q    <= buf_q[1];
                xsize_q   <= in_data_i;
                wr_pend_q <= (cur_op == OP_XFER_WR);
              end else begin
                state_q <= ST_SEND;
                rd_q    <= '0;
              end
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
        end
        ST_SEND: begin
          if (pkt_ready_i) begin
            rd_q <= rd_q + CNT_W'(1);
            if (pkt_eop_o) state_q <= ST_COLLECT;
          end
        end
        default: state_q <= ST_COLLECT;
      endcase
    end
  end

  assign pkt_valid_o   = (state_q == ST_SEND);
  assign pkt_data_o    = buf_q[rd_q];
  assign pkt_sop_o     = (rd_q == '0);
  assign pkt_eop_o     = (rd_q == need_q - CNT_W'(1));
  assign xfer_start_o  = xs_q;
  assign xfer_read_o   = xr_q;
  assign xfer_pos_o    = xpos_q;
  assign xfer_size_o   = xsize_q;
  assign xfer_wvalid_o = wr_pend_q && in_valid_i;
  assign xfer_wdata_o  = in_data_i;

  cmd_shadow #(.DATA_W(DATA_W), .NUM_SH(NUM_SH)) u_shadow (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .done_i      (done),
    .op_i        (cur_op),
    .w0_i        (w0),
    .tex_w_i     (tex_w),
    .dirty_clr_i (dirty_clr_i),
    .shadow_o    (shadow_o),
    .status_o    (status_o),
    .dirty_o     (dirty_o)
  );

  // R4
  hold_on_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_o && !pkt_ready_i) |=> (pkt_valid_o && $stable(pkt_data_o)
      && $stable(pkt_sop_o) && $stable(pkt_eop_o)));
  // R2
  mid_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_o && pkt_ready_i && !pkt_eop_o) |=> (pkt_valid_o && !pkt_sop_o));
  // R8
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_start_o |=> !xfer_start_o);
  // R9
  no_parse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_wvalid_o |=> (!pkt_valid_o && cnt_q == $past(cnt_q)));
endmodule

// File: tb/cmd_framer_tb_top.sv
`timescale 1ns/1ps
module cmd_framer_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid_i = 1'b0;
  logic [31:0]  in_data_i = '0;
  logic         in_ready_o;
  logic         pkt_valid_o, pkt_sop_o, pkt_eop_o;
  logic [31:0]  pkt_data_o;
  logic         pkt_ready_i = 1'b1;
  logic         xfer_start_o, xfer_read_o, xfer_wvalid_o;
  logic [31:0]  xfer_pos_o, xfer_size_o, xfer_wdata_o;
  logic         xfer_done_i = 1'b0;
  logic [255:0] shadow_o;
  logic [12:0]  status_o;
  logic         dirty_o;
  logic         dirty_clr_i = 1'b0;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;
  int rdy_mode = 0;
  int xs_cnt = 0;
  logic        xs_rd;
  logic [31:0] xs_pos, xs_size;
  logic [33:0] exp_q[$];
  logic [31:0] xw_q[$];
  logic [31:0] pw [12];

  always #10 clk = ~clk;

  cmd_framer dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid_i), .in_data_i(in_data_i), .in_ready_o(in_ready_o),
    .pkt_valid_o(pkt_valid_o), .pkt_data_o(pkt_data_o), .pkt_sop_o(pkt_sop_o),
    .pkt_eop_o(pkt_eop_o), .pkt_ready_i(pkt_ready_i),
    .xfer_start_o(xfer_start_o), .xfer_read_o(xfer_read_o),
    .xfer_pos_o(xfer_pos_o), .xfer_size_o(xfer_size_o),
    .xfer_wvalid_o(xfer_wvalid_o), .xfer_wdata_o(xfer_wdata_o),
    .xfer_done_i(xfer_done_i), .shadow_o(shadow_o), .status_o(status_o),
    .dirty_o(dirty_o), .dirty_clr_i(dirty_clr_i)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  // renderer ready pattern, changed away from both edges
  initial begin
    int ctr = 0;
    forever begin
      @(posedge clk); #3;
      ctr++;
      case (rdy_mode)
        1:       pkt_ready_i = (ctr % 3) != 1;
        2:       pkt_ready_i = 1'b0;
        default: pkt_ready_i = 1'b1;
      endcase
    end
  end

  // monitor: scoreboard compare of forwarded words and transfer data
  initial begin
    forever begin
      @(negedge clk); #5;
      if (rst_n) begin
        if (pkt_valid_o && pkt_ready_i) begin
          if (exp_q.size() == 0) chk(1'b0, "R2 unexpected word", {30'd0, pkt_sop_o, pkt_eop_o, pkt_data_o}, 64'd0);
          else begin
            logic [33:0] e;
            e = exp_q.pop_front();
            chk({pkt_sop_o, pkt_eop_o, pkt_data_o} == e, "R2/R3 packet word",
                {30'd0, pkt_sop_o, pkt_eop_o, pkt_data_o}, {30'd0, e});
          end
        end
        if (xfer_wvalid_o) begin
          if (xw_q.size() == 0) chk(1'b0, "R9 unexpected transfer word", {32'd0, xfer_wdata_o}, 64'd0);
          else begin
            logic [31:0] e;
            e = xw_q.pop_front();
            chk(xfer_wdata_o == e, "R9 transfer word", {32'd0, xfer_wdata_o}, {32'd0, e});
          end
        end
        if (xfer_start_o) begin
          xs_cnt++;
          xs_rd = xfer_read_o;
          xs_pos = xfer_pos_o;
          xs_size = xfer_size_o;
        end
      end
    end
  end

  task automatic send_word(input logic [31:0] w);
    @(negedge clk);
    in_valid_i = 1'b1;
    in_data_i = w;
    #1;
    while (!in_ready_o) begin
      @(negedge clk); #1;
    end
    @(posedge clk); #1;
    in_valid_i = 1'b0;
  endtask

  task automatic fill(input logic [7:0] op, input logic [31:0] base);
    pw[0] = {op, base[23:0]};
    for (int i = 1; i < 12; i++) pw[i] = (base ^ (32'h01010101 * i)) + i;
  endtask

  task automatic send_buf(input int n, input bit fwd);
    if (fwd)
      for (int i = 0; i < n; i++) exp_q.push_back({(i == 0), (i == n - 1), pw[i]});
    for (int i = 0; i < n; i++) send_word(pw[i]);
  endtask

  task automatic drain(input string req);
    int guard = 0;
    do begin
      @(negedge clk); #6;
      guard++;
    end while ((exp_q.size() != 0 || pkt_valid_o) && guard < 200);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  task automatic pkt(input logic [7:0] op, input int n, input logic [31:0] base, input string req);
    fill(op, base);
    send_buf(n, 1'b1);
    drain(req);
  endtask

  task automatic clr_dirty();
    @(negedge clk); dirty_clr_i = 1'b1;
    @(negedge clk); dirty_clr_i = 1'b0;
  endtask

  function automatic logic [31:0] sh(input int n);
    return shadow_o[n*32 +: 32];
  endfunction

  initial begin
    #(20 * 100000);
    chk(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    int n0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #5;
    // R1 reset state
    chk(in_ready_o == 1'b1, "R1 in_ready", in_ready_o, 1);
    chk(!pkt_valid_o && !xfer_start_o, "R1 outputs idle", {pkt_valid_o, xfer_start_o}, 0);
    chk(!dirty_o && status_o == 13'd0, "R1 dirty/status", {dirty_o, status_o}, 0);
    chk(shadow_o == '0, "R1 shadows", shadow_o[63:0], 0);

    // R2 lengths with a toggling ready (also R4)
    rdy_mode = 1;
    pkt(8'h20, 4, 32'h00A1B2C3, "R2 op20 length 4");
    pkt(8'h3C, 12, 32'h00123456, "R2 op3C length 12");
    pkt(8'h23, 4, 32'h00777777, "R2 op23 length 4");
    rdy_mode = 0;
    pkt(8'h60, 3, 32'h00010203, "R2 op60 length 3");
    pkt(8'h6A, 2, 32'h00040506, "R2 op6A length 2");
    pkt(8'h80, 4, 32'h00070809, "R2 op80 length 4");
    pkt(8'h02, 3, 32'h000A0B0C, "R2 op02 length 3");

    // R3 one-word packets
    pkt(8'h00, 1, 32'h00000011, "R3 op00 single");
    pkt(8'h1F, 1, 32'h00000022, "R3 op1F single");
    pkt(8'h6D, 1, 32'h00000033, "R3 op6D single");

    // R11 / R4 input stalled while forwarding under held-low ready
    rdy_mode = 2;
    fill(8'h21, 32'h00C0FFEE);
    send_buf(4, 1'b1);
    @(negedge clk); #5;
    chk(pkt_valid_o && !in_ready_o, "R11 input stalled", {pkt_valid_o, in_ready_o}, 2'b10);
    chk(pkt_sop_o && pkt_data_o == pw[0], "R4 held first word", pkt_data_o, pw[0]);
    rdy_mode = 0;
    drain("R4 drain after hold");

    // R5 / R10 settings
    pkt(8'hE1, 1, 32'h000005A5, "R5 opE1 forwarded");
    chk(sh(1) == 32'hE10005A5, "R5 shadow1", sh(1), 32'hE10005A5);
    pkt(8'hE6, 1, 32'h00000002, "R5 opE6 forwarded");
    chk(sh(6) == 32'hE6000002, "R5 shadow6", sh(6), 32'hE6000002);
    chk(status_o == 13'h15A5, "R10 status", status_o, 13'h15A5);

    // R6 texture field patch
    fill(8'h24, 32'h00111111);
    pw[4] = 32'h00000123;
    send_buf(7, 1'b1);
    drain("R6 op24 packet");
    chk(sh(1) == 32'hE1000523, "R6 shadow1 from word 4", sh(1), 32'hE1000523);
    fill(8'h34, 32'h00222222);
    pw[4] = 32'h000001FF;
    pw[5] = 32'hABCDE0F0;
    send_buf(9, 1'b1);
    drain("R6 op34 packet");
    chk(sh(1) == 32'hE10004F0, "R6 shadow1 from word 5", sh(1), 32'hE10004F0);
    chk(status_o == 13'h14F0, "R10 status after patch", status_o, 13'h14F0);

    // R7 dirty flag
    clr_dirty();
    #5;
    chk(!dirty_o, "R7 cleared", dirty_o, 0);
    pkt(8'h01, 1, 32'h0, "R7 op01 forwarded");
    pkt(8'hE3, 1, 32'h00000444, "R7 opE3 forwarded");
    chk(!dirty_o, "R7 no set for 01/E3", dirty_o, 0);
    chk(sh(3) == 32'hE3000444, "R5 shadow3", sh(3), 32'hE3000444);

    // R8 read transfer
    n0 = xs_cnt;
    fill(8'hC0, 32'h0);
    pw[1] = 32'h00100020;
    pw[2] = 32'h00080004;
    send_buf(3, 1'b0);
    repeat (3) @(negedge clk);
    #5;
    chk(xs_cnt == n0 + 1, "R8 one start pulse", xs_cnt - n0, 1);
    chk(xs_rd == 1'b1 && xs_pos == 32'h00100020 && xs_size == 32'h00080004,
        "R8 read params", {xs_rd, xs_pos}, {1'b1, 32'h00100020});
    chk(!dirty_o, "R7 no set for C0", dirty_o, 0);

    pkt(8'hBF, 1, 32'h0, "R7 opBF forwarded");
    chk(dirty_o, "R7 set for BF", dirty_o, 1);
    clr_dirty();

    // R8 / R9 write transfer and data routing
    n0 = xs_cnt;
    fill(8'hA0, 32'h0);
    pw[1] = 32'h01F00300;
    pw[2] = 32'h00020002;
    send_buf(3, 1'b0);
    repeat (2) @(negedge clk);
    #5;
    chk(xs_cnt == n0 + 1 && xs_rd == 1'b0 && xs_size == 32'h00020002,
        "R8 write params", {xs_rd, xs_size}, {1'b0, 32'h00020002});
    chk(dirty_o, "R7 set for A0", dirty_o, 1);
    xw_q.push_back(32'hE3123456);
    xw_q.push_back(32'h20000000);
    send_word(32'hE3123456);
    send_word(32'h20000000);
    repeat (3) @(negedge clk);
    #5;
    chk(xw_q.size() == 0, "R9 words routed", xw_q.size(), 0);
    chk(sh(3) == 32'hE3000444, "R9 shadow3 untouched", sh(3), 32'hE3000444);
    chk(!pkt_valid_o, "R9 no packet", pkt_valid_o, 0);
    @(negedge clk); xfer_done_i = 1'b1;
    @(negedge clk); xfer_done_i = 1'b0;
    pkt(8'hE3, 1, 32'h00000999, "R9 parse resumes");
    chk(sh(3) == 32'hE3000999, "R9 shadow3 after done", sh(3), 32'hE3000999);

    repeat (4) @(negedge clk);
    summary();
  end
endmodule